// File: doc/BRIEF.md
# Fail-Safe Clock Monitor

This block watches the selected system clock against an independent, slower reference clock (the internal low-power RC time base that the watchdog also uses). It runs a request/acknowledge round trip between the two domains. A request toggled in the reference domain must be echoed back by the monitored clock within a fixed window of reference cycles. When the echo does not return in time, the monitored clock is taken to have stopped. The block then raises a sticky failure flag and a request telling the clock-switching logic to fall back to the internal fast RC oscillator.

Monitoring is held off in two ways, so that a slow oscillator start-up is never reported as a failure. After power-on reset, a brown-out event or a wake from sleep, the block first counts a parameterised start-up delay, but only when the selected source is one of the crystal-based or secondary oscillator modes. It then waits until a fresh round trip proves that the monitored clock is running. The whole monitor is idle while the clock-switching configuration enable is low. A detected failure touches nothing outside this block, so the watchdog that shares the time base keeps running.

Top module: `clk_fail_monitor`

## Requirements
- R1: While `rst_n` is low, `fail_flag` and `fallback_req` are 0.
- R2: While `cfg_en` is 0, `fail_flag` and `fallback_req` are 0 whatever the monitored clock does, and a flag that was set is cleared. When `cfg_en` returns to 1, monitoring restarts as after a brown-out.
- R3: For `osc_mode` values 3 (crystal), 4 (high-speed crystal), 5 (crystal with PLL), 6 (high-speed crystal with PLL) and 7 (secondary oscillator), a restart first waits `START_CYC` reference cycles. A monitored clock that stops within that delay is never reported.
- R4: For `osc_mode` values 0 (fast RC), 1 (fast RC with PLL) and 2 (external clock input), a restart skips the delay and goes straight to the running check.
- R5: A monitored clock that never starts after a restart produces no failure, however long it stays stopped.
- R6: Once monitoring is active, a monitored clock running well above the reference rate never sets the flag. A monitored clock that stops sets `fail_flag` within `WINDOW` plus a few reference cycles.
- R7: `fail_flag` is sticky. It stays set when the monitored clock resumes and when `wake_evt` pulses.
- R8: A one-cycle `flag_clr` pulse clears `fail_flag` on the next reference edge. Monitoring then resumes with the running check and no delay: a clock that is still stopped is not reported again, and a clock that runs and then stops is reported again.
- R9: `bor_evt` clears the flag and restarts monitoring. `wake_evt` restarts monitoring when no failure is flagged. Either restart applies the delay of R3 to delayed modes.
- R10: `fallback_req` is high exactly when `fail_flag` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference (low-power RC) clock; all control logic runs on it |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mon_clk | input | 1 | Monitored system clock |
| cfg_en | input | 1 | Clock-switching/monitor configuration enable, 1 = enabled |
| osc_mode | input | 3 | Selected oscillator mode, encoded as in R3/R4 |
| bor_evt | input | 1 | Brown-out event pulse, reference domain |
| wake_evt | input | 1 | Wake-from-sleep event pulse, reference domain |
| flag_clr | input | 1 | Software clear of the failure flag, one-cycle pulse |
| fail_flag | output | 1 | Sticky clock-failure flag |
| fallback_req | output | 1 | Request to switch the system clock to the fast RC source |

## Verification
The hardest situation to reach from the ports is telling the start-up delay apart from the running check, because both simply keep the flag low. The table stops the monitored clock a fixed number of reference cycles after a brown-out restart, under each oscillator mode. The same stop time must then leave the flag clear in a delayed mode and set it in an undelayed mode. Late stops in delayed modes show that monitoring does begin once the delay has run out. Directed tests cover a clock that never starts, a clear while the clock is still dead, and a wake that restarts monitoring.

// File: rtl/clk_fail_monitor.sv
`timescale 1ns/1ps
module clk_fail_monitor #(
  parameter int START_CYC = 64,
  parameter int WINDOW    = 8
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       mon_clk,
  input  logic       cfg_en,
  input  logic [2:0] osc_mode,
  input  logic       bor_evt,
  input  logic       wake_evt,
  input  logic       flag_clr,
  output logic       fail_flag,
  output logic       fallback_req
);
  localparam int CMAX = (START_CYC > WINDOW) ? START_CYC : WINDOW;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_OFF, S_DELAY, S_WAIT, S_MON, S_FAIL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          req, seen;
  logic [1:0]    m_sync, r_sync;

  wire done    = (r_sync[1] == req);
  wire delayed = (osc_mode >= 3'd3);
  wire restart = bor_evt | (wake_evt & (st != S_FAIL)) | (st == S_OFF);

  always_ff @(posedge mon_clk or negedge rst_n)
    if (!rst_n) m_sync <= '0;
    else        m_sync <= {m_sync[0], req};

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) r_sync <= '0;
    else        r_sync <= {r_sync[0], m_sync[1]};

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      cnt  <= '0;
      req  <= 1'b0;
      seen <= 1'b0;
    end else if (!cfg_en) begin
      st   <= S_OFF;
      cnt  <= '0;
      seen <= 1'b0;
    end else if (restart) begin
      st   <= delayed ? S_DELAY : S_WAIT;
      cnt  <= '0;
      seen <= 1'b0;
    end else begin
      case (st)
        S_DELAY:
          if (cnt == CW'(START_CYC - 1)) begin
            st  <= S_WAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_WAIT:
          if (done) begin
            req  <= ~req;
            seen <= 1'b1;
            if (seen) begin
              st  <= S_MON;
              cnt <= '0;
            end
          end
        S_MON:
          if (done) begin
            req <= ~req;
            cnt <= '0;
          end else if (cnt == CW'(WINDOW - 1)) st <= S_FAIL;
          else cnt <= cnt + 1'b1;
        S_FAIL:
          if (flag_clr) begin
            st   <= S_WAIT;
            seen <= 1'b0;
          end
        default: st <= S_OFF;
      endcase
    end
  end

  assign fail_flag    = (st == S_FAIL);
  assign fallback_req = (st == S_FAIL);
endmodule

module clk_fail_monitor_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic cfg_en,
  input logic bor_evt,
  input logic flag_clr,
  input logic fail_flag,
  input logic fallback_req
);
  always @(posedge ref_clk)
    if (!rst_n) assert_reset_quiet_R1: assert (!fail_flag && !fallback_req);

  assert_disabled_quiet_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !cfg_en |=> (!fail_flag && !fallback_req));

  assert_flag_sticky_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_flag && cfg_en && !flag_clr && !bor_evt) |=> fail_flag);

  assert_flag_clear_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_flag && flag_clr) |=> !fail_flag);

  assert_bor_clears_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    bor_evt |=> !fail_flag);

  assert_fallback_rise_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(fail_flag) |-> fallback_req);

  assert_fallback_fall_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(fallback_req) |-> !fail_flag);
endmodule

bind clk_fail_monitor clk_fail_monitor_chk u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .cfg_en(cfg_en), .bor_evt(bor_evt),
  .flag_clr(flag_clr), .fail_flag(fail_flag), .fallback_req(fallback_req)
);

// File: tb/sim_clk_fail_monitor.sv
`timescale 1ns/1ps
module sim_clk_fail_monitor;
  logic ref_clk = 1'b0, mon_clk = 1'b0, mon_run = 1'b1;
  logic rst_n = 1'b0, cfg_en = 1'b1, bor_evt = 1'b0, wake_evt = 1'b0, flag_clr = 1'b0;
  logic [2:0] osc_mode = 3'd2;
  logic fail_flag, fallback_req;
  int tests = 0, failed = 0;
  bit done = 0;

  clk_fail_monitor #(.START_CYC(64), .WINDOW(8)) u0 (
    .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .cfg_en(cfg_en),
    .osc_mode(osc_mode), .bor_evt(bor_evt), .wake_evt(wake_evt), .flag_clr(flag_clr),
    .fail_flag(fail_flag), .fallback_req(fallback_req));

  always #2.5 ref_clk = ~ref_clk;
  initial forever begin
    #0.8;
    if (mon_run) mon_clk = ~mon_clk;
  end

  typedef struct packed { logic [2:0] mode; logic [7:0] stop; logic exp; logic [3:0] tag; } vec_t;
  localparam vec_t VEC [8] = '{
    '{3'd3, 8'd40,  1'b0, 4'd3}, '{3'd7, 8'd40,  1'b0, 4'd3},
    '{3'd5, 8'd60,  1'b0, 4'd3}, '{3'd2, 8'd40,  1'b1, 4'd4},
    '{3'd0, 8'd40,  1'b1, 4'd4}, '{3'd1, 8'd20,  1'b1, 4'd4},
    '{3'd4, 8'd100, 1'b1, 4'd6}, '{3'd6, 8'd120, 1'b1, 4'd6}};

  function automatic string tname(int t);
    case (t)
      3: return "R3";
      4: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulse_bor();
    bor_evt = 1'b1; tick(1); bor_evt = 1'b0;
  endtask

  task automatic make_fail();
    mon_run = 1'b1; osc_mode = 3'd2; pulse_bor(); tick(30);
    mon_run = 1'b0; tick(30);
  endtask

  initial begin
    tick(5);
    check("R1 flag in reset", fail_flag, 1'b0);
    check("R1 fallback in reset", fallback_req, 1'b0);
    rst_n = 1'b1;
    tick(5);

    foreach (VEC[i]) begin
      mon_run = 1'b1; osc_mode = VEC[i].mode; tick(10);
      pulse_bor();
      tick(int'(VEC[i].stop) - 1);
      mon_run = 1'b0;
      tick(80);
      check(tname(int'(VEC[i].tag)), fail_flag, VEC[i].exp);
      check("R10 fallback follows flag", fallback_req, VEC[i].exp);
      mon_run = 1'b1; tick(5);
    end

    // R5: clock never starts
    mon_run = 1'b0; osc_mode = 3'd2; pulse_bor(); tick(400);
    check("R5 never started", fail_flag, 1'b0);
    // R6: steady running then stop
    mon_run = 1'b1; tick(300);
    check("R6 running clock", fail_flag, 1'b0);
    mon_run = 1'b0; tick(30);
    check("R6 stop detected", fail_flag, 1'b1);
    check("R10 fallback raised", fallback_req, 1'b1);
    // R7: sticky
    mon_run = 1'b1; tick(50);
    check("R7 sticky after resume", fail_flag, 1'b1);
    wake_evt = 1'b1; tick(1); wake_evt = 1'b0; tick(20);
    check("R7 sticky after wake", fail_flag, 1'b1);
    // R8: software clear
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(1);
    check("R8 cleared", fail_flag, 1'b0);
    tick(30); mon_run = 1'b0; tick(30);
    check("R8 refail after clear", fail_flag, 1'b1);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(300);
    check("R8 clear with dead clock", fail_flag, 1'b0);
    // R9: brown-out clears, wake restarts with delay
    make_fail();
    check("R9 precondition", fail_flag, 1'b1);
    osc_mode = 3'd4; pulse_bor(); tick(1);
    check("R9 bor clears", fail_flag, 1'b0);
    mon_run = 1'b1; osc_mode = 3'd3; tick(150);
    wake_evt = 1'b1; tick(1); wake_evt = 1'b0; tick(20);
    mon_run = 1'b0; tick(100);
    check("R9 wake restarts delay", fail_flag, 1'b0);
    // R2: enable low
    make_fail();
    cfg_en = 1'b0; tick(2);
    check("R2 disable clears flag", fail_flag, 1'b0);
    check("R2 disable clears fallback", fallback_req, 1'b0);
    tick(200);
    check("R2 quiet while disabled", fail_flag, 1'b0);
    mon_run = 1'b1; osc_mode = 3'd2; cfg_en = 1'b1; tick(30);
    mon_run = 1'b0; tick(30);
    check("R2 monitoring after re-enable", fail_flag, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog: got hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule